// File: doc/BRIEF.md
# Diagnostic Evidence Accumulator

This block collects evidence for one fault candidate during logic diagnosis. Each test pattern brings two fail vectors. One marks the outputs where the device under diagnosis failed. The other marks the outputs where the simulated fault machine for the candidate failed. From the two vectors the block forms four per-pattern figures:

- predictions: outputs that fail in both vectors.
- mispredictions: outputs that fail only in the fault machine.
- unexplained errors: outputs that fail only in the device.
- conditional score: the smaller of predictions and mispredictions.

The block adds each figure into its own running total. A pattern counts only when the candidate is observable under it.

The conditional total stays at zero for a fault that acts as a plain stuck-at, a conditional one included. It becomes positive once the candidate both explains and contradicts failures within a single pattern. A controller clears the totals before each test set. It then presents one pattern per strobe and reads the totals after the last pattern. Ranking of candidates is done elsewhere.

Top module: `evidence_accum`

## Requirements
- R1: After reset all four totals read zero and `upd_vld` is low.
- R2: For an accepted observable pattern, `pred_total` grows by the number of bit positions set in both `dut_fail` and `fm_fail`.
- R3: For an accepted observable pattern, `misp_total` grows by the number of positions set in `fm_fail` and clear in `dut_fail`.
- R4: For an accepted observable pattern, `unexp_total` grows by the number of positions set in `dut_fail` and clear in `fm_fail`.
- R5: For an accepted observable pattern, `cond_total` grows by the minimum of the prediction and misprediction counts of that pattern. `cond_total` therefore never exceeds `pred_total` or `misp_total`.
- R6: A strobed pattern with `observ` low leaves all four totals unchanged.
- R7: An observable pattern with `dut_fail` all zero changes only `misp_total`.
- R8: Each total saturates at 2^CNT_W-1 and never wraps. A total never decreases except through clear.
- R9: `clr` high at a clock edge sets all totals to zero. It takes priority over a pattern strobed at the same edge, and that pattern is dropped.
- R10: `upd_vld` is high for exactly the cycle after an edge at which `pat_vld` was high and `clr` was low. At that cycle the totals include that pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of all totals |
| pat_vld | input | 1 | Pattern strobe, one pattern per high cycle |
| observ | input | 1 | Candidate observable under this pattern |
| dut_fail | input | N_OUT | Device fail vector, 1 = output failed |
| fm_fail | input | N_OUT | Fault-machine fail vector, 1 = output failed |
| pred_total | output | CNT_W | Accumulated predictions |
| misp_total | output | CNT_W | Accumulated mispredictions |
| unexp_total | output | CNT_W | Accumulated unexplained errors |
| cond_total | output | CNT_W | Accumulated per-pattern minimum of predictions and mispredictions |
| upd_vld | output | 1 | Totals updated by a pattern in the previous edge |

## Verification
The properties assume that `clr`, `pat_vld` and `observ` are known at every edge after reset. They also assume that the fail vectors carry meaning only in cycles where the strobe is high. No property depends on the values that idle cycles hold. The stimulus drives every control to a defined level at each falling edge. It mixes strobed cycles, idle cycles and clear cycles, and sets `observ` low on about a quarter of the random patterns, so that each property's antecedent is reached. A long run of all-fail fault-machine vectors against a passing device forces the misprediction total into saturation. This exercises the no-wrap properties at the ceiling.

// File: rtl/evd_pkg.sv
// Package: shared indices for the four evidence figures.
// Assumes consumers size per-pattern counts with cnt_width().
package evd_pkg;

    typedef enum int {
        EV_PRED = 0,
        EV_MISP = 1,
        EV_UNEX = 2,
        EV_COND = 3
    } ev_idx_e;

    localparam int EV_NUM = 4;

    // Width needed to hold a count from 0 to n inclusive.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/evd_popcount.sv
// Module: combinational population count of a W-bit vector.
// Assumes OW is large enough to hold the value W.
module evd_popcount #(
    parameter int W  = 16,
    parameter int OW = 5
) (
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] cnt
);

    // Sum every bit of the input vector.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + OW'(vec[i]);
        end
    end

endmodule

// File: rtl/evd_pattern_eval.sv
// Module: per-pattern evidence figures from two fail vectors, in one cycle.
// Assumes both vectors use 1 = failing output. Purely combinational.
module evd_pattern_eval
    import evd_pkg::*;
#(
    parameter int N  = 16,
    parameter int PW = cnt_width(N)
) (
    input  logic [N-1:0]             dut_fail,
    input  logic [N-1:0]             fm_fail,
    output logic [EV_NUM-1:0][PW-1:0] fig
);

    localparam int NMASK = 3;

    logic [NMASK-1:0][N-1:0]  mask;
    logic [NMASK-1:0][PW-1:0] pc;

    // Form the overlap, fault-only and device-only masks.
    always_comb begin
        mask[EV_PRED] = dut_fail & fm_fail;
        mask[EV_MISP] = fm_fail & ~dut_fail;
        mask[EV_UNEX] = dut_fail & ~fm_fail;
    end

    genvar g;
    generate
        for (g = 0; g < NMASK; g++) begin : g_pc
            evd_popcount #(.W(N), .OW(PW)) u_pc (
                .vec (mask[g]),
                .cnt (pc[g])
            );
        end
    endgenerate

    // Pass the counts through and derive the conditional minimum.
    always_comb begin
        fig[EV_PRED] = pc[EV_PRED];
        fig[EV_MISP] = pc[EV_MISP];
        fig[EV_UNEX] = pc[EV_UNEX];
        fig[EV_COND] = (pc[EV_PRED] < pc[EV_MISP]) ? pc[EV_PRED] : pc[EV_MISP];
    end

endmodule

// File: rtl/evd_sat_acc.sv
// Module: saturating accumulator with synchronous clear.
// Assumes IW <= CW. Clear wins over enable.
module evd_sat_acc #(
    parameter int IW = 5,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [IW-1:0] inc,
    output logic [CW-1:0] total
);

    localparam logic [CW-1:0] MAXV = {CW{1'b1}};

    logic [CW:0]   wide_sum;
    logic [CW-1:0] next_sum;

    // Add with one guard bit and clamp at the ceiling.
    always_comb begin
        wide_sum = {1'b0, total} + {{(CW + 1 - IW){1'b0}}, inc};
        next_sum = wide_sum[CW] ? MAXV : wide_sum[CW-1:0];
    end

    // Hold, clear or accumulate the running total.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            total <= '0;
        end else if (en) begin
            total <= next_sum;
        end
    end

endmodule

// File: rtl/evidence_accum.sv
// Module: top of the evidence accumulator for one fault candidate.
// Assumes one pattern per cycle with pat_vld high. Totals are registered.
module evidence_accum
    import evd_pkg::*;
#(
    parameter int N_OUT = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pat_vld,
    input  logic             observ,
    input  logic [N_OUT-1:0] dut_fail,
    input  logic [N_OUT-1:0] fm_fail,
    output logic [CNT_W-1:0] pred_total,
    output logic [CNT_W-1:0] misp_total,
    output logic [CNT_W-1:0] unexp_total,
    output logic [CNT_W-1:0] cond_total,
    output logic             upd_vld
);

    localparam int PW = cnt_width(N_OUT);

    logic [EV_NUM-1:0][PW-1:0]    fig;
    logic [EV_NUM-1:0][CNT_W-1:0] tot;
    logic                         acc_en;

    evd_pattern_eval #(.N(N_OUT), .PW(PW)) u_eval (
        .dut_fail (dut_fail),
        .fm_fail  (fm_fail),
        .fig      (fig)
    );

    // Count only strobed patterns under which the candidate is observable.
    assign acc_en = pat_vld && observ;

    genvar g;
    generate
        for (g = 0; g < EV_NUM; g++) begin : g_acc
            evd_sat_acc #(.IW(PW), .CW(CNT_W)) u_acc (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .en    (acc_en),
                .inc   (fig[g]),
                .total (tot[g])
            );
        end
    endgenerate

    // Map the accumulator bank onto named outputs.
    assign pred_total  = tot[EV_PRED];
    assign misp_total  = tot[EV_MISP];
    assign unexp_total = tot[EV_UNEX];
    assign cond_total  = tot[EV_COND];

    // Flag the cycle after a pattern was taken in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_vld <= 1'b0;
        end else begin
            upd_vld <= pat_vld && !clr;
        end
    end

endmodule

// File: rtl/evidence_accum_chk.sv
// Checker: temporal properties of the evidence accumulator, bound to the top.
// Assumes the controls are known at every edge after reset.
module evidence_accum_chk #(
    parameter int N_OUT = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             pat_vld,
    input logic             observ,
    input logic [N_OUT-1:0] dut_fail,
    input logic [CNT_W-1:0] pred_total,
    input logic [CNT_W-1:0] misp_total,
    input logic [CNT_W-1:0] unexp_total,
    input logic [CNT_W-1:0] cond_total,
    input logic             upd_vld
);

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (pred_total == '0 && misp_total == '0 && unexp_total == '0 && cond_total == '0 && !upd_vld)); // R1

    AST_COND_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (cond_total <= pred_total) && (cond_total <= misp_total)); // R5

    AST_UNOBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pat_vld && !observ && !clr) |=> ($stable(pred_total) && $stable(misp_total) && $stable(unexp_total) && $stable(cond_total))); // R6

    AST_PASS_ONLY_MISP: assert property (@(posedge clk) disable iff (!rst_n) (pat_vld && observ && !clr && dut_fail == '0) |=> ($stable(pred_total) && $stable(unexp_total) && $stable(cond_total))); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !clr |=> (pred_total >= $past(pred_total) && misp_total >= $past(misp_total) && unexp_total >= $past(unexp_total) && cond_total >= $past(cond_total))); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (pred_total == '0 && misp_total == '0 && unexp_total == '0 && cond_total == '0)); // R9

    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (pat_vld && !clr) |=> upd_vld); // R10

    AST_UPD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(pat_vld && !clr) |=> !upd_vld); // R10

endmodule

bind evidence_accum evidence_accum_chk #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .pat_vld     (pat_vld),
    .observ      (observ),
    .dut_fail    (dut_fail),
    .pred_total  (pred_total),
    .misp_total  (misp_total),
    .unexp_total (unexp_total),
    .cond_total  (cond_total),
    .upd_vld     (upd_vld)
);

// File: tb/sim_evidence_accum.sv
// Bench: random and directed patterns, expected totals from bench functions.
module sim_evidence_accum;

    localparam int N  = 12;
    localparam int CW = 8;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          pat_vld = 1'b0;
    logic          observ = 1'b0;
    logic [N-1:0]  dut_fail = '0;
    logic [N-1:0]  fm_fail = '0;
    logic [CW-1:0] pred_total, misp_total, unexp_total, cond_total;
    logic          upd_vld;

    int n_chk = 0;
    int n_fail = 0;
    int e_pred = 0, e_misp = 0, e_unex = 0, e_cond = 0;
    bit finished = 1'b0;
    int cyc = 0;

    always #2 clk = ~clk;

    evidence_accum #(.N_OUT(N), .CNT_W(CW)) u0 (
        .clk (clk), .rst_n (rst_n), .clr (clr), .pat_vld (pat_vld),
        .observ (observ), .dut_fail (dut_fail), .fm_fail (fm_fail),
        .pred_total (pred_total), .misp_total (misp_total),
        .unexp_total (unexp_total), .cond_total (cond_total),
        .upd_vld (upd_vld)
    );

    function automatic int pop(input logic [N-1:0] v);
        int s = 0;
        for (int i = 0; i < N; i++) s += int'(v[i]);
        return s;
    endfunction

    function automatic int sat(input int a, input int b);
        return (a + b > MAXV) ? MAXV : a + b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_totals(input string tag);
        check(int'(pred_total)  == e_pred, {tag, " R2"}, int'(pred_total),  e_pred);
        check(int'(misp_total)  == e_misp, {tag, " R3"}, int'(misp_total),  e_misp);
        check(int'(unexp_total) == e_unex, {tag, " R4"}, int'(unexp_total), e_unex);
        check(int'(cond_total)  == e_cond, {tag, " R5"}, int'(cond_total),  e_cond);
    endtask

    // Apply one pattern at a falling edge; check after the next rising edge.
    task automatic apply(input logic [N-1:0] d, input logic [N-1:0] f, input bit obs, input string tag);
        int s, m, t;
        dut_fail = d; fm_fail = f; observ = obs; pat_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pat_vld = 1'b0;
        s = pop(d & f); m = pop(f & ~d); t = pop(d & ~f);
        if (obs) begin
            e_pred = sat(e_pred, s);
            e_misp = sat(e_misp, m);
            e_unex = sat(e_unex, t);
            e_cond = sat(e_cond, (s < m) ? s : m);
        end
        check(upd_vld == 1'b1, {tag, " R10 upd"}, int'(upd_vld), 1);
        check_totals(tag);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        e_pred = 0; e_misp = 0; e_unex = 0; e_cond = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pred_total == '0 && misp_total == '0 && unexp_total == '0 && cond_total == '0,
              "R1 totals", int'(pred_total) + int'(misp_total) + int'(unexp_total) + int'(cond_total), 0);
        check(upd_vld == 1'b0, "R1 upd", int'(upd_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: overlap 2, fault-only 2, device-only 2
        apply(12'h0F0, 12'h0CC, 1'b1, "dir mixed");
        // Directed: fault-only 5, overlap 1 -> conditional 1
        apply(12'h001, 12'h03F, 1'b1, "dir cond");
        // R6: unobservable pattern with failures everywhere
        apply(12'hFFF, 12'h00F, 1'b0, "R6 unobs");
        // R7: passing device pattern
        apply(12'h000, 12'hA5A, 1'b1, "R7 pass");
        // R10: idle cycle drops upd_vld
        @(negedge clk);
        check(upd_vld == 1'b0, "R10 idle", int'(upd_vld), 0);

        // R9: clear with a simultaneous pattern, which must be dropped
        dut_fail = 12'hFFF; fm_fail = 12'hFFF; observ = 1'b1; pat_vld = 1'b1;
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0; pat_vld = 1'b0;
        e_pred = 0; e_misp = 0; e_unex = 0; e_cond = 0;
        check_totals("R9 clear");
        check(upd_vld == 1'b0, "R9 R10 upd", int'(upd_vld), 0);

        // Random patterns
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0] d, f;
            bit obs;
            d = N'($urandom) & N'($urandom);
            f = N'($urandom);
            obs = ($urandom % 4) != 0;
            apply(d, f, obs, "rand");
            if ($urandom % 8 == 0) @(negedge clk);
            if (k % 50 == 49) do_clear();
        end

        // R8: saturate the misprediction total with passing device patterns
        do_clear();
        for (int k = 0; k < 30; k++) apply(12'h000, 12'hFFF, 1'b1, "R8 sat");
        check(int'(misp_total) == MAXV, "R8 ceiling", int'(misp_total), MAXV);
        check(pred_total == '0, "R7 R8 pred", int'(pred_total), 0);
        // R8: other totals saturate and hold at the ceiling
        for (int k = 0; k < 30; k++) apply(12'hFFF, 12'hFFF, 1'b1, "R8 sat2");
        check(int'(pred_total) == MAXV, "R8 pred ceiling", int'(pred_total), MAXV);

        finish_run();
    end

endmodule